// File: doc/BRIEF.md
# Subordinate Processor Reset Controller with Watchdog

This block sits beside one subordinate processor and owns its reset line. A host writes a small control word through a shared-memory style write port. The subordinate can only read that word, through a read-only port. The word carries three things: a host reset-control bit, a reset-status bit that mirrors the real state of the reset line, and a field that picks which sensor channel the subordinate takes data from.

A watchdog down-counter runs while the subordinate is out of reset, and the subordinate reloads it with a kick pulse. If the count runs out, the block forces the reset line on, latches that condition and sends the host a one-cycle interrupt pulse. The reset stays on until the host performs an explicit release. To release, the host must take the control bit from 1 to 0; clearing a bit that is already 0 does not count. Writes come as a full load, a set-mask or a clear-mask, so no field needs a read-modify-write.

Top module: `sub_reset_ctrl`

## Requirements
- R1: The control word is laid out as bit 0 = reset-control (host writable), bit 1 = reset-status (read-only; writes to it are ignored), bits [CHAN_W+1:2] = channel select. It is visible on `ctrl_rdata` at all times.
- R2: The reset-status bit equals the `sub_reset` output in every cycle.
- R3: While the reset-control bit is 1, `sub_reset` is 1. When the control bit is 0 and no watchdog trip is latched, `sub_reset` is 0.
- R4: With `sub_reset` low and no kick, the watchdog expires on the (WDOG_RELOAD+1)-th rising edge after its last reload. At that edge `sub_reset` rises and `wdog_irq` goes high.
- R5: After a watchdog trip, `sub_reset` stays 1 until a write takes the control bit from 1 to 0. A clear of the control bit while it is already 0 does not release the line.
- R6: After reset (`rst_n` low), the control bit is 1, channel select is 0, `sub_reset` is 1 and `wdog_irq` is 0. With CHAN_W=3, `ctrl_rdata` reads 5'b00011.
- R7: `wr_op` encodes 0 = load the word from `wr_data`, 1 = set the bits that are 1 in `wr_data`, 2 = clear the bits that are 1 in `wr_data`, 3 = no effect. A clear-then-set of the channel field leaves the control bit unchanged. Without a write, the channel select holds.
- R8: A kick pulse reloads the counter to WDOG_RELOAD. While `sub_reset` is 1, the counter is held at WDOG_RELOAD, so no trip can occur.
- R9: `wdog_irq` is high for exactly one cycle per expiry and does not repeat while the trip stays latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Host write strobe |
| wr_op | input | 2 | Write operation: load, set-mask, clear-mask, no-op |
| wr_data | input | CHAN_W+2 | Write data or mask |
| wdog_kick | input | 1 | Watchdog reload pulse from the subordinate |
| ctrl_rdata | output | CHAN_W+2 | Control word as seen by the subordinate |
| sub_reset | output | 1 | Active-high reset line to the subordinate |
| chan_sel | output | CHAN_W | Selected sensor channel |
| wdog_irq | output | 1 | One-cycle pulse to the host on watchdog expiry |

## Verification
The bench sweeps the kick position across every cycle of the watchdog window, then checks that expiry lands on exactly the predicted edge. A counter that is off by one, or that does not hold while in reset, shows up as an early or late trip. After each trip it looks for the pulse to drop after one cycle and for the line to stay high. It also tries a clear of an already-zero control bit, which a design that releases on any clear would wrongly honour. All eight channel values go through the clear-then-set pattern, and the bench also tries writes to the status bit and the no-op code, which a sloppy mask decoder would let change the word.

// File: rtl/sub_reset_pkg.sv
// Shared encodings for the subordinate reset controller.
// Assumes the control word keeps the control bit at 0, the status bit
// at 1 and the channel field starting at bit 2.
package sub_reset_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_NOP  = 2'd3
    } wr_op_e;

    localparam int CTL_BIT  = 0;
    localparam int STAT_BIT = 1;
    localparam int CHAN_LSB = 2;

    // Next value of one host-writable bit under a given write operation.
    function automatic logic bit_next(input wr_op_e op, input logic cur, input logic d);
        case (op)
            OP_LOAD: bit_next = d;
            OP_SET:  bit_next = cur | d;
            OP_CLR:  bit_next = cur & ~d;
            default: bit_next = cur;
        endcase
    endfunction

endpackage

// File: rtl/sub_reset_word.sv
// Host-writable part of the control word: reset-control bit and channel
// field, one flop lane per bit, updated by load / set-mask / clear-mask.
// Also flags a release, which is a write that takes the control bit 1 -> 0.
// Assumes the status bit is owned elsewhere, so its write data is ignored.
module sub_reset_word
    import sub_reset_pkg::*;
#(
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [1:0]        wr_op,
    input  logic [CHAN_W+1:0] wr_data,
    output logic              ctl_o,
    output logic [CHAN_W-1:0] chan_o,
    output logic              release_o
);
    localparam int REG_W = CHAN_W + 2;

    wr_op_e op;
    logic   ctl_next;
    logic   unused_stat_wr;

    assign op             = wr_op_e'(wr_op);
    assign unused_stat_wr = wr_data[STAT_BIT];

    // Next value of the control bit, used by its lane and by the release detect.
    always_comb begin
        ctl_next = ctl_o;
        if (wr_valid) ctl_next = bit_next(op, ctl_o, wr_data[CTL_BIT]);
    end

    // A release needs the control bit to fall on an actual write.
    assign release_o = wr_valid & ctl_o & ~ctl_next;

    for (genvar i = 0; i < REG_W; i++) begin : g_lane
        if (i == CTL_BIT) begin : g_ctl
            // Control lane: resets to 1 so the subordinate starts held.
            always_ff @(posedge clk) begin
                if (!rst_n) ctl_o <= 1'b1;
                else        ctl_o <= ctl_next;
            end
        end else if (i >= CHAN_LSB) begin : g_chan
            // Channel lane: resets to 0, changes only on a write.
            always_ff @(posedge clk) begin
                if (!rst_n)        chan_o[i-CHAN_LSB] <= 1'b0;
                else if (wr_valid) chan_o[i-CHAN_LSB] <= bit_next(op, chan_o[i-CHAN_LSB], wr_data[i]);
            end
        end
    end

endmodule

// File: rtl/sub_reset_wdog.sv
// Watchdog down-counter with a sticky trip flag and a one-cycle interrupt.
// Counts only while the reset line is low; a kick or a held line reloads it.
// On reaching zero without a kick it sets the trip flag and pulses irq.
// Assumes release_i arrives only while the line is high.
module sub_reset_wdog #(
    parameter int WDOG_W      = 16,
    parameter int WDOG_RELOAD = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic kick_i,
    input  logic release_i,
    output logic trip_o,
    output logic irq_o
);
    localparam logic [WDOG_W-1:0] RLD = WDOG_W'(WDOG_RELOAD);

    logic [WDOG_W-1:0] cnt_q;
    logic              expire;

    // Expiry: running, count at zero, and no kick arriving this cycle.
    assign expire = ~line_i & ~kick_i & (cnt_q == '0);

    // Counter: reload while held or kicked, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= RLD;
        else if (line_i || kick_i || expire) cnt_q <= RLD;
        else                                 cnt_q <= cnt_q - 1'b1;
    end

    // Trip flag: set on expiry, cleared only by an explicit host release.
    always_ff @(posedge clk) begin
        if (!rst_n)         trip_o <= 1'b0;
        else if (expire)    trip_o <= 1'b1;
        else if (release_i) trip_o <= 1'b0;
    end

    // Interrupt: high for the single cycle after each expiry edge.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= expire;
    end

endmodule

// File: rtl/sub_reset_ctrl.sv
// Reset controller for one subordinate processor. The host writes the
// control word; the subordinate reads it. The reset line is the host
// control bit OR the sticky watchdog trip, and the status bit reports it.
// Assumes a synchronous active-low reset and single-clock operation.
module sub_reset_ctrl
    import sub_reset_pkg::*;
#(
    parameter int CHAN_W      = 3,
    parameter int WDOG_W      = 16,
    parameter int WDOG_RELOAD = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [1:0]        wr_op,
    input  logic [CHAN_W+1:0] wr_data,
    input  logic              wdog_kick,
    output logic [CHAN_W+1:0] ctrl_rdata,
    output logic              sub_reset,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              wdog_irq
);
    logic ctl;
    logic release_pulse;
    logic trip;

    sub_reset_word #(.CHAN_W(CHAN_W)) u_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_op     (wr_op),
        .wr_data   (wr_data),
        .ctl_o     (ctl),
        .chan_o    (chan_sel),
        .release_o (release_pulse)
    );

    sub_reset_wdog #(.WDOG_W(WDOG_W), .WDOG_RELOAD(WDOG_RELOAD)) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (sub_reset),
        .kick_i    (wdog_kick),
        .release_i (release_pulse),
        .trip_o    (trip),
        .irq_o     (wdog_irq)
    );

    // Reset line: held by the host bit or by a latched watchdog trip.
    assign sub_reset = ctl | trip;

    // Read view: channel field, live line state, host control bit.
    always_comb begin
        ctrl_rdata                           = '0;
        ctrl_rdata[CTL_BIT]                  = ctl;
        ctrl_rdata[STAT_BIT]                 = sub_reset;
        ctrl_rdata[CHAN_LSB +: CHAN_W]       = chan_sel;
    end

endmodule

// File: rtl/sub_reset_ctrl_chk.sv
// Property checker for sub_reset_ctrl, attached by bind.
module sub_reset_ctrl_chk
    import sub_reset_pkg::*;
#(
    parameter int CHAN_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [1:0]        wr_op,
    input logic              ctl_bit,
    input logic              sub_reset,
    input logic [CHAN_W-1:0] chan_sel,
    input logic              wdog_irq
);
    p_ctl_forces_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_bit |-> sub_reset);

    p_irq_with_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_irq |-> sub_reset);

    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_irq |=> !wdog_irq);

    p_hold_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_reset && !wr_valid) |=> sub_reset);

    p_idle_clear_no_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_reset && !ctl_bit && wr_valid && wr_op == OP_CLR) |=> sub_reset);

    p_chan_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid || wr_op == OP_NOP) |=> $stable(chan_sel));

endmodule

bind sub_reset_ctrl sub_reset_ctrl_chk #(.CHAN_W(CHAN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_op     (wr_op),
    .ctl_bit   (ctrl_rdata[0]),
    .sub_reset (sub_reset),
    .chan_sel  (chan_sel),
    .wdog_irq  (wdog_irq)
);

// File: tb/sim_sub_reset_ctrl.sv
`timescale 1ns/1ps
module sim_sub_reset_ctrl;
    localparam int CW  = 3;
    localparam int RLD = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [1:0]    wr_op = 2'd3;
    logic [CW+1:0] wr_data = '0;
    logic          wdog_kick = 1'b0;
    logic [CW+1:0] ctrl_rdata;
    logic          sub_reset;
    logic [CW-1:0] chan_sel;
    logic          wdog_irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sub_reset_ctrl #(.CHAN_W(CW), .WDOG_W(16), .WDOG_RELOAD(RLD)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_op(wr_op),
        .wr_data(wr_data), .wdog_kick(wdog_kick), .ctrl_rdata(ctrl_rdata),
        .sub_reset(sub_reset), .chan_sel(chan_sel), .wdog_irq(wdog_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] op, input logic [CW+1:0] d);
        wr_valid = 1'b1;
        wr_op    = op;
        wr_data  = d;
        step();
        wr_valid = 1'b0;
        wr_op    = 2'd3;
        wr_data  = '0;
    endtask

    // Watchdog on the bench itself: a hung run is one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [CW+1:0] word;
        @(negedge clk);
        repeat (4) step();
        rst_n = 1'b1;

        // R6: reset state, R1 layout, R2 status
        chk("R6 rdata", int'(ctrl_rdata), 3);
        chk("R6 line", int'(sub_reset), 1);
        chk("R6 chan", int'(chan_sel), 0);
        chk("R6 irq", int'(wdog_irq), 0);
        chk("R2 status", int'(ctrl_rdata[1]), int'(sub_reset));

        // R8: counter held while line asserted, no trip over a long hold
        for (int c = 0; c < 4 * RLD; c++) begin
            step();
            chk("R8 no irq while held", int'(wdog_irq), 0);
        end

        // R7/R1: clear-then-set of every channel value
        for (int v = 0; v < (1 << CW); v++) begin
            wr(2'd2, {{CW{1'b1}}, 2'b00});
            wr(2'd1, {CW'(v), 2'b00});
            chk("R7 chan", int'(chan_sel), v);
            chk("R1 rdata chan", int'(ctrl_rdata), (v << 2) | 3);
        end

        // R1: writing the status bit has no effect
        word = ctrl_rdata;
        wr(2'd2, 5'b00010);
        chk("R1 status clear ignored", int'(ctrl_rdata), int'(word));
        // R7: no-op code changes nothing
        wr(2'd3, '1);
        chk("R7 nop", int'(ctrl_rdata), int'(word));
        // R7: full load
        wr(2'd0, {3'd5, 2'b01});
        chk("R7 load", int'(ctrl_rdata), (5 << 2) | 3);

        // R3: control bit drives the line
        wr(2'd2, 5'b00001);
        chk("R3 released line", int'(sub_reset), 0);
        chk("R2 status low", int'(ctrl_rdata), 5 << 2);
        wr(2'd1, 5'b00001);
        chk("R3 held line", int'(sub_reset), 1);
        chk("R2 status high", int'(ctrl_rdata), (5 << 2) | 3);

        // R4/R8/R9/R5: sweep kick position across the whole window
        for (int j = 0; j <= RLD; j++) begin
            wr(2'd2, 5'b00001); // release at edge P0
            chk("R3 release", int'(sub_reset), 0);
            if (j >= 1) begin
                for (int c = 1; c < j; c++) begin
                    step();
                    chk("R4 no early trip", int'(sub_reset), 0);
                end
                wdog_kick = 1'b1;
                step();
                wdog_kick = 1'b0;
                chk("R8 kick no trip", int'(wdog_irq), 0);
            end
            for (int c = 0; c < RLD; c++) begin
                step();
                chk("R4 no early irq", int'(wdog_irq), 0);
                chk("R4 line low", int'(sub_reset), 0);
            end
            step();
            chk("R4 irq at expiry", int'(wdog_irq), 1);
            chk("R4 line at expiry", int'(sub_reset), 1);
            chk("R2 status at expiry", int'(ctrl_rdata[1]), 1);
            step();
            chk("R9 single pulse", int'(wdog_irq), 0);
            for (int c = 0; c < 8; c++) begin
                step();
                chk("R5 sticky line", int'(sub_reset), 1);
                chk("R9 no repeat", int'(wdog_irq), 0);
            end
            wr(2'd2, 5'b00001); // control already 0: not a release
            chk("R5 idle clear keeps line", int'(sub_reset), 1);
            step();
            chk("R5 still held", int'(sub_reset), 1);
            wr(2'd1, 5'b00001);
            chk("R5 chan kept", int'(chan_sel), 5);
        end

        // R5: a proper 1 -> 0 write releases after a trip
        wr(2'd2, 5'b00001);
        chk("R5 release after trip", int'(sub_reset), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule